// File: doc/BRIEF.md
# I2C Slave Bus Status Tracker

This block sits next to an I2C slave byte engine and keeps the status flags a host reads to follow a transfer. It watches the synchronised SCL and SDA lines for START and STOP conditions. It also takes strobes from the byte engine: an address byte matched, a data byte completed, and an ACK phase. From these it tracks which bus condition came last, whether the last byte was an address or data, the direction bit of the most recent address match, the state of the single transfer buffer, and whether the host must reload the address compare value during a 10-bit address sequence.

A START is SDA falling while SCL stays high. A STOP is SDA rising while SCL stays high. Lines, strobes and host actions are all sampled on the system clock. Each flag changes at the clock edge that samples its cause. Dropping the module enable clears every flag and holds them cleared.

Top module: `i2cs_status_track`

## Requirements
- R1: When SDA goes 1 to 0 between two samples, with SCL high in both, the start flag (status bit 3) is 1 after that edge and the stop flag is 0.
- R2: When SDA goes 0 to 1 between two samples, with SCL high in both, the stop flag (status bit 4) is 1 after that edge and the start flag is 0.
- R3: After reset the whole status word is 0, and the start and stop flags are never both 1.
- R4: The data/address flag (status bit 5) goes to 0 on an address match and to 1 on a data-byte-done strobe. A START (first or repeated) also forces it to 0.
- R5: The read/write flag (status bit 2) takes the direction input on an address match, with 1 meaning read. A START, a STOP or an ACK strobe clears it. An address match wins over an ACK in the same cycle.
- R6: With 10-bit mode on, the first and second address matches after a STOP or after enabling set the update-address flag (status bit 1). Later matches before the next STOP, such as the one after a repeated START, leave it alone. A host write of the address register clears it, but a set in the same cycle wins. With 10-bit mode off it is never set.
- R7: In a write transfer (last address match had direction 0), data-byte-done sets the buffer-full flag (status bit 0). A host read of the buffer clears it. If both happen in the same cycle, the flag ends at 1.
- R8: In a read transfer (last address match had direction 1), a host buffer load sets buffer-full, and data-byte-done clears it.
- R9: While the enable is low, every status bit is 0 from the next edge on. Line activity and strobes are ignored.
- R10: The status word is {data/address, stop, start, read/write, update-address, buffer-full}, from bit 5 down to bit 0.
- R11: Any combination of line values where SCL is low in either sample produces neither a START nor a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Module enable; low clears and holds all flags |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| ten_bit_i | input | 1 | 10-bit addressing mode |
| addr_match_i | input | 1 | Strobe: an address byte matched |
| rw_bit_i | input | 1 | Direction bit accompanying the address match (1 = read) |
| byte_done_i | input | 1 | Strobe: a data byte finished shifting |
| ack_i | input | 1 | Strobe: ACK phase reached |
| buf_load_i | input | 1 | Host wrote the transmit buffer |
| buf_read_i | input | 1 | Host read the receive buffer |
| host_addr_wr_i | input | 1 | Host wrote the address compare register |
| status_o | output | 6 | Status word, layout per R10 |

## Verification
Two pairs of functions can act in the same cycle. A received data byte can set buffer-full in the same cycle that the host read clears it. An address match can load the direction bit in the same cycle that an ACK clears it. The bench drives each pair on one clock edge. For the direction bit it sweeps all eight combinations of match, direction and ACK, starting from a flag already at 1, and computes the expected bit from the priority rule. The START/STOP detector is swept over all sixteen before-and-after line pairs. The enable is toggled between cases so that each verdict depends only on the transition under test.

// File: rtl/i2cs_stat_pkg.sv
package i2cs_stat_pkg;

  localparam int STAT_W  = 6;
  localparam int BIT_BF  = 0;
  localparam int BIT_UA  = 1;
  localparam int BIT_RW  = 2;
  localparam int BIT_STA = 3;
  localparam int BIT_STO = 4;
  localparam int BIT_DA  = 5;

  typedef struct packed {
    logic da;
    logic sto;
    logic sta;
    logic rw;
    logic ua;
    logic bf;
  } stat_t;

  // SDA falls while SCL is held high across both samples
  function automatic logic f_is_start(input logic c_prev, input logic d_prev,
                                      input logic c_now, input logic d_now);
    return c_prev & c_now & d_prev & ~d_now;
  endfunction

  // SDA rises while SCL is held high across both samples
  function automatic logic f_is_stop(input logic c_prev, input logic d_prev,
                                     input logic c_now, input logic d_now);
    return c_prev & c_now & ~d_prev & d_now;
  endfunction

  function automatic logic [STAT_W-1:0] f_pack(input stat_t s);
    return s;
  endfunction

endpackage

// File: rtl/i2cs_line_watch.sv
module i2cs_line_watch
  import i2cs_stat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o
);

  logic scl_q, sda_q;

  // previous line levels; idle bus is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = en_i & f_is_start(scl_q, sda_q, scl_i, sda_i);
  assign stop_o  = en_i & f_is_stop (scl_q, sda_q, scl_i, sda_i);

  AST_NO_COND_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_i |-> (!start_o && !stop_o)); // R11

endmodule

// File: rtl/i2cs_addr_seq.sv
module i2cs_addr_seq #(
  parameter int MATCH_PHASES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic ten_bit_i,
  input  logic stop_i,
  input  logic addr_match_i,
  input  logic host_addr_wr_i,
  output logic ua_o
);

  localparam int PH_W = $clog2(MATCH_PHASES + 1);

  logic [PH_W-1:0] phase_q;
  logic            early_match;
  logic            ua_set;

  assign early_match = (phase_q < PH_W'(MATCH_PHASES));
  assign ua_set      = en_i & ten_bit_i & addr_match_i & early_match;

  // count address matches since the last STOP, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        phase_q <= '0;
    else if (!en_i || stop_i)          phase_q <= '0;
    else if (addr_match_i && early_match) phase_q <= phase_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ua_o <= 1'b0;
    else if (!en_i)          ua_o <= 1'b0;
    else if (ua_set)         ua_o <= 1'b1;
    else if (host_addr_wr_i) ua_o <= 1'b0;
  end

  AST_UA_NEEDS_10B: assert property (@(posedge clk) disable iff (!rst_n)
    (!ten_bit_i && !ua_o) |=> !ua_o); // R6

  AST_UA_HOST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && host_addr_wr_i && !addr_match_i) |=> !ua_o); // R6

endmodule

// File: rtl/i2cs_buf_track.sv
module i2cs_buf_track (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic addr_match_i,
  input  logic rw_bit_i,
  input  logic byte_done_i,
  input  logic buf_load_i,
  input  logic buf_read_i,
  output logic bf_o
);

  logic xfer_rd_q;
  logic rx_fill, tx_drain;

  // transfer direction held from the address match to the next bus condition
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 xfer_rd_q <= 1'b0;
    else if (!en_i)             xfer_rd_q <= 1'b0;
    else if (addr_match_i)      xfer_rd_q <= rw_bit_i;
    else if (start_i || stop_i) xfer_rd_q <= 1'b0;
  end

  assign rx_fill  = byte_done_i & ~xfer_rd_q;
  assign tx_drain = byte_done_i &  xfer_rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      bf_o <= 1'b0;
    else if (!en_i)                  bf_o <= 1'b0;
    else if (rx_fill || buf_load_i)  bf_o <= 1'b1;
    else if (tx_drain || buf_read_i) bf_o <= 1'b0;
  end

  AST_BF_RX_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && byte_done_i && !xfer_rd_q) |=> bf_o); // R7

  AST_BF_TX_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && byte_done_i && xfer_rd_q && !buf_load_i) |=> !bf_o); // R8

endmodule

// File: rtl/i2cs_status_track.sv
module i2cs_status_track
  import i2cs_stat_pkg::*;
#(
  parameter int MATCH_PHASES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              ten_bit_i,
  input  logic              addr_match_i,
  input  logic              rw_bit_i,
  input  logic              byte_done_i,
  input  logic              ack_i,
  input  logic              buf_load_i,
  input  logic              buf_read_i,
  input  logic              host_addr_wr_i,
  output logic [STAT_W-1:0] status_o
);

  logic start_evt, stop_evt;
  logic sta_q, sto_q, da_q, rw_q;
  logic ua_w, bf_w;
  stat_t stat;

  i2cs_line_watch u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .start_o (start_evt),
    .stop_o  (stop_evt)
  );

  i2cs_addr_seq #(.MATCH_PHASES(MATCH_PHASES)) u_addr (
    .clk            (clk),
    .rst_n          (rst_n),
    .en_i           (en_i),
    .ten_bit_i      (ten_bit_i),
    .stop_i         (stop_evt),
    .addr_match_i   (addr_match_i),
    .host_addr_wr_i (host_addr_wr_i),
    .ua_o           (ua_w)
  );

  i2cs_buf_track u_buf (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .start_i      (start_evt),
    .stop_i       (stop_evt),
    .addr_match_i (addr_match_i),
    .rw_bit_i     (rw_bit_i),
    .byte_done_i  (byte_done_i),
    .buf_load_i   (buf_load_i),
    .buf_read_i   (buf_read_i),
    .bf_o         (bf_w)
  );

  // most recent bus condition: each one clears the other
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_q <= 1'b0;
      sto_q <= 1'b0;
    end else if (!en_i) begin
      sta_q <= 1'b0;
      sto_q <= 1'b0;
    end else if (start_evt) begin
      sta_q <= 1'b1;
      sto_q <= 1'b0;
    end else if (stop_evt) begin
      sta_q <= 1'b0;
      sto_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     da_q <= 1'b0;
    else if (!en_i)                 da_q <= 1'b0;
    else if (start_evt || addr_match_i) da_q <= 1'b0;
    else if (byte_done_i)           da_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 rw_q <= 1'b0;
    else if (!en_i)                             rw_q <= 1'b0;
    else if (addr_match_i)                      rw_q <= rw_bit_i;
    else if (start_evt || stop_evt || ack_i)    rw_q <= 1'b0;
  end

  always_comb begin
    stat.da  = da_q;
    stat.sto = sto_q;
    stat.sta = sta_q;
    stat.rw  = rw_q;
    stat.ua  = ua_w;
    stat.bf  = bf_w;
  end

  assign status_o = f_pack(stat);

  AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (status_o[BIT_STA] && !status_o[BIT_STO])); // R1

  AST_STOP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (status_o[BIT_STO] && !status_o[BIT_STA])); // R2

  AST_COND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(status_o[BIT_STA] && status_o[BIT_STO])); // R3

  AST_DA_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && byte_done_i && !addr_match_i && !start_evt) |=> status_o[BIT_DA]); // R4

  AST_RW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !addr_match_i && (start_evt || stop_evt || ack_i)) |=> !status_o[BIT_RW]); // R5

  AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (status_o == '0)); // R9

endmodule

// File: tb/i2cs_status_track_tb_top.sv
module i2cs_status_track_tb_top;

  localparam int B_BF = 0, B_UA = 1, B_RW = 2, B_STA = 3, B_STO = 4, B_DA = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, scl = 1'b1, sda = 1'b1, ten_bit = 1'b0;
  logic addr_match = 1'b0, rw_bit = 1'b0, byte_done = 1'b0, ack = 1'b0;
  logic buf_load = 1'b0, buf_read = 1'b0, host_wr = 1'b0;
  logic [5:0] status;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  i2cs_status_track dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .scl_i(scl), .sda_i(sda),
    .ten_bit_i(ten_bit), .addr_match_i(addr_match), .rw_bit_i(rw_bit),
    .byte_done_i(byte_done), .ack_i(ack), .buf_load_i(buf_load),
    .buf_read_i(buf_read), .host_addr_wr_i(host_wr), .status_o(status)
  );

  task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic lines(input logic c, input logic d);
    scl = c; sda = d; tick();
  endtask

  task automatic gen_start();
    lines(1'b0, 1'b1); lines(1'b1, 1'b1); lines(1'b1, 1'b0);
  endtask

  task automatic gen_stop();
    lines(1'b0, 1'b0); lines(1'b1, 1'b0); lines(1'b1, 1'b1);
  endtask

  task automatic do_addr(input logic dir);
    addr_match = 1'b1; rw_bit = dir; tick(); addr_match = 1'b0; rw_bit = 1'b0;
  endtask

  task automatic reenable();
    en = 1'b0; tick(); en = 1'b1; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R3 reset word", status, 6'b0);
    en = 1'b1;
    tick();

    // R1 R2 R11: sweep every before/after pair of line levels
    for (int k = 0; k < 16; k++) begin
      logic cp, dp, cn, dn, e_sta, e_sto;
      {cp, dp, cn, dn} = 4'(k);
      lines(1'b0, dp);
      lines(cp, dp);
      reenable();
      lines(cn, dn);
      e_sta = cp & cn & dp & ~dn;
      e_sto = cp & cn & ~dp & dn;
      chk($sformatf("R1 R2 R11 lines %b%b->%b%b", cp, dp, cn, dn),
          {status[B_STO], status[B_STA]}, {4'b0, e_sto, e_sta});
    end

    // R3: each condition displaces the other
    reenable();
    gen_start();
    gen_stop();
    chk("R2 stop after start", {status[B_STO], status[B_STA]}, 6'b10);
    gen_start();
    chk("R1 start after stop", {status[B_STO], status[B_STA]}, 6'b01);

    // R5: sweep match/direction/ACK from a flag at 1
    for (int k = 0; k < 8; k++) begin
      logic a, r, q, e_rw;
      {a, r, q} = 3'(k);
      do_addr(1'b1);
      addr_match = a; rw_bit = r; ack = q;
      tick();
      addr_match = 1'b0; rw_bit = 1'b0; ack = 1'b0;
      e_rw = a ? r : (q ? 1'b0 : 1'b1);
      chk($sformatf("R5 match=%b dir=%b ack=%b", a, r, q), {5'b0, status[B_RW]}, {5'b0, e_rw});
    end
    do_addr(1'b1);
    gen_stop();
    chk("R5 stop clears rw", {5'b0, status[B_RW]}, 6'b0);
    do_addr(1'b1);
    gen_start();
    chk("R5 start clears rw", {5'b0, status[B_RW]}, 6'b0);

    // R4 data/address
    do_addr(1'b0);
    chk("R4 address byte", {5'b0, status[B_DA]}, 6'b0);
    byte_done = 1'b1; tick(); byte_done = 1'b0;
    chk("R4 data byte", {5'b0, status[B_DA]}, 6'b1);
    gen_start();
    chk("R4 repeated start", {5'b0, status[B_DA]}, 6'b0);

    // R6 update-address in 10-bit mode
    ten_bit = 1'b1;
    gen_stop(); gen_start();
    do_addr(1'b0);
    chk("R6 first match", {5'b0, status[B_UA]}, 6'b1);
    host_wr = 1'b1; tick(); host_wr = 1'b0;
    chk("R6 host clear", {5'b0, status[B_UA]}, 6'b0);
    do_addr(1'b0);
    chk("R6 second match", {5'b0, status[B_UA]}, 6'b1);
    host_wr = 1'b1; tick(); host_wr = 1'b0;
    gen_start();
    do_addr(1'b1);
    chk("R6 match after repeated start", {5'b0, status[B_UA]}, 6'b0);
    gen_stop(); gen_start();
    addr_match = 1'b1; host_wr = 1'b1; tick(); addr_match = 1'b0; host_wr = 1'b0;
    chk("R6 set beats host clear", {5'b0, status[B_UA]}, 6'b1);
    host_wr = 1'b1; tick(); host_wr = 1'b0;
    ten_bit = 1'b0;
    gen_stop(); gen_start();
    do_addr(1'b0);
    chk("R6 7-bit mode no request", {5'b0, status[B_UA]}, 6'b0);

    // R7 receive buffer
    byte_done = 1'b1; tick(); byte_done = 1'b0;
    chk("R7 receive fills", {5'b0, status[B_BF]}, 6'b1);
    chk("R10 word after receive", status, 6'b101001);
    buf_read = 1'b1; tick(); buf_read = 1'b0;
    chk("R7 host read empties", {5'b0, status[B_BF]}, 6'b0);
    byte_done = 1'b1; buf_read = 1'b1; tick(); byte_done = 1'b0; buf_read = 1'b0;
    chk("R7 fill beats read", {5'b0, status[B_BF]}, 6'b1);
    buf_read = 1'b1; tick(); buf_read = 1'b0;

    // R8 transmit buffer
    gen_start();
    do_addr(1'b1);
    ack = 1'b1; tick(); ack = 1'b0;
    buf_load = 1'b1; tick(); buf_load = 1'b0;
    chk("R8 host load fills", {5'b0, status[B_BF]}, 6'b1);
    byte_done = 1'b1; tick(); byte_done = 1'b0;
    chk("R8 transmit done empties", {5'b0, status[B_BF]}, 6'b0);

    // R9 disable
    buf_load = 1'b1; tick(); buf_load = 1'b0;
    do_addr(1'b1);
    en = 1'b0; tick();
    chk("R9 disable clears", status, 6'b0);
    gen_stop();
    gen_start();
    do_addr(1'b1);
    byte_done = 1'b1; buf_load = 1'b1; tick(); byte_done = 1'b0; buf_load = 1'b0;
    chk("R9 ignored while off", status, 6'b0);
    en = 1'b1; tick();
    chk("R9 re-enable quiet", status, 6'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule